// File: doc/BRIEF.md
# Two-Line Serial Rate and Pad Controller

This block sets the timing and the pad drive for a two-wire serial port. One of the two lines is chosen as the base line, which normally carries the clock. Its bit rate comes from a programmable divider. The other line runs either at the base rate or at one eighth of it. Each line has its own pad mode: input only, push-pull output, or open-drain output. The block also holds the shift-order choice, which a data shifter next to it reads.

Software loads a control word and a direction word through a small write port while the run input is low. It then raises run. While run is high, the divider produces a toggle strobe for each line, and each line's level flips on its own strobe. Lowering run clears the counters and returns both lines to idle high. An open-drain or input-only pad is released in that state.

Top module: `dual_line_rate_ctrl`

## Requirements
- R1: After reset both direction fields are 00 and all control fields are 0. The pads are therefore open-drain and released (a_oe = b_oe = 0, a_do = b_do = 0), msb_first = 1, and no strobe fires.
- R2: While run_en is high, base_tick fires once every D clocks, in the D-th, 2D-th, ... cycle since run_en rose. D is the divider field, control word bits [10:3]. A divider of 60 gives a 120-clock bit period, which is 400 kbit/s from a 48 MHz clock.
- R3: Divider values 0 and 1 behave as 2.
- R4: Control word bit 1 selects the base line: 1 puts the base level on line A and the other level on line B; 0 does the reverse.
- R5: Control word bit 2 sets the rate of the other line: 0 makes other_tick equal to base_tick; 1 makes it fire only on every 8th base_tick.
- R6: Each line level is high when run_en rises. It toggles in the cycle after each of its strobes.
- R7: Direction word bits [3:2] give line A's mode and bits [1:0] give line B's mode. With the high bit set the pad is input only (oe = 0, do = 0). Mode 01 is push-pull (oe = 1, do = level). Mode 00 is open-drain (oe = not level, do = 0).
- R8: Control word bit 0 selects bit order: 0 gives msb_first = 1 and 1 gives msb_first = 0.
- R9: A write with cfg_we high while run_en is high changes nothing. cfg_sel = 0 addresses the control word and cfg_sel = 1 the direction word. Writes take effect on the next clock.
- R10: In the cycle after run_en is low, both counters are cleared and both levels are high, and no strobe fires while run_en stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enables the rate counters; configuration is locked while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = direction word |
| cfg_wdata | input | 11 | Write data |
| a_oe | output | 1 | Line A pad output enable |
| a_do | output | 1 | Line A pad output data |
| b_oe | output | 1 | Line B pad output enable |
| b_do | output | 1 | Line B pad output data |
| base_tick | output | 1 | Base-line toggle strobe |
| other_tick | output | 1 | Other-line toggle strobe |
| msb_first | output | 1 | Shift order for the data shifter |

## Verification
The strobes are combinational from counter state and run_en, so they are due in the same cycle in which the count reaches its limit. The line levels and the pad outputs change one clock after that strobe. Configuration writes and a fall of run_en show on the outputs one clock after the edge that samples them. The bench holds a behavioural model that advances on each rising edge from the inputs it sampled there. Every output is compared against the model on the falling edge, so each result is checked in exactly the cycle it is due, and a stray or late strobe shows up as a miscompare.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  // control word bit positions (divider sits above the three flags)
  localparam int CTL_ORDER_BIT = 0;
  localparam int CTL_BSEL_BIT  = 1;
  localparam int CTL_SLOW_BIT  = 2;
  localparam int CTL_DIV_LSB   = 3;

  typedef enum logic [1:0] {
    PAD_OPEN_DRAIN = 2'b00,
    PAD_PUSH_PULL  = 2'b01,
    PAD_INPUT_A    = 2'b10,
    PAD_INPUT_B    = 2'b11
  } pad_mode_e;

  function automatic logic pad_oe(input pad_mode_e m, input logic lvl);
    case (m)
      PAD_PUSH_PULL:  return 1'b1;
      PAD_OPEN_DRAIN: return ~lvl;
      default:        return 1'b0;
    endcase
  endfunction

  function automatic logic pad_do(input pad_mode_e m, input logic lvl);
    return (m == PAD_PUSH_PULL) ? lvl : 1'b0;
  endfunction

endpackage

// File: rtl/lrc_rate_divider.sv
module lrc_rate_divider #(
  parameter int DIV_W      = 8,
  parameter int SLOW_RATIO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             slow_sel,
  output logic             base_tick,
  output logic             other_tick,
  output logic             base_lvl,
  output logic             other_lvl
);
  localparam int SLOW_W = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;

  // terminal count of the base counter; divider values under 2 act as 2
  function automatic logic [DIV_W-1:0] last_count(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? DIV_W'(1) : d - DIV_W'(1);
  endfunction

  logic [DIV_W-1:0]  base_cnt;
  logic [SLOW_W-1:0] slow_cnt;
  logic              slow_tick;

  assign base_tick  = run && (base_cnt == last_count(div));
  assign slow_tick  = base_tick && (slow_cnt == SLOW_W'(SLOW_RATIO - 1));
  assign other_tick = slow_sel ? slow_tick : base_tick;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      base_cnt  <= '0;
      slow_cnt  <= '0;
      base_lvl  <= 1'b1;
      other_lvl <= 1'b1;
    end else begin
      base_cnt <= base_tick ? '0 : base_cnt + DIV_W'(1);
      if (base_tick) begin
        slow_cnt <= slow_tick ? '0 : slow_cnt + SLOW_W'(1);
        base_lvl <= ~base_lvl;
      end
      if (other_tick) other_lvl <= ~other_lvl;
    end
  end
endmodule

// File: rtl/lrc_line_pad.sv
module lrc_line_pad
  import lrc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       lvl,
  output logic       oe,
  output logic       dout
);
  pad_mode_e m;
  assign m    = pad_mode_e'(mode);
  assign oe   = pad_oe(m, lvl);
  assign dout = pad_do(m, lvl);
endmodule

// File: rtl/dual_line_rate_ctrl.sv
module dual_line_rate_ctrl
  import lrc_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int SLOW_RATIO = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_en,
  input  logic                     cfg_we,
  input  logic                     cfg_sel,
  input  logic [CTL_DIV_LSB+DIV_W-1:0] cfg_wdata,
  output logic                     a_oe,
  output logic                     a_do,
  output logic                     b_oe,
  output logic                     b_do,
  output logic                     base_tick,
  output logic                     other_tick,
  output logic                     msb_first
);
  localparam int N_LINES = 2;   // index 1 = line A, index 0 = line B

  logic [DIV_W-1:0]       div_q;
  logic                   bsel_q, slow_q, order_q;
  logic [2*N_LINES-1:0]   dir_q;
  logic                   base_lvl, other_lvl;
  logic [N_LINES-1:0]     line_lvl, line_oe, line_do;
  logic                   cfg_write_ok;

  assign cfg_write_ok = cfg_we && !run_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      bsel_q  <= 1'b0;
      slow_q  <= 1'b0;
      order_q <= 1'b0;
      dir_q   <= '0;
    end else if (cfg_write_ok) begin
      if (cfg_sel) begin
        dir_q <= cfg_wdata[2*N_LINES-1:0];
      end else begin
        div_q   <= cfg_wdata[CTL_DIV_LSB +: DIV_W];
        bsel_q  <= cfg_wdata[CTL_BSEL_BIT];
        slow_q  <= cfg_wdata[CTL_SLOW_BIT];
        order_q <= cfg_wdata[CTL_ORDER_BIT];
      end
    end
  end

  lrc_rate_divider #(.DIV_W(DIV_W), .SLOW_RATIO(SLOW_RATIO)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_en),
    .div        (div_q),
    .slow_sel   (slow_q),
    .base_tick  (base_tick),
    .other_tick (other_tick),
    .base_lvl   (base_lvl),
    .other_lvl  (other_lvl)
  );

  assign line_lvl[1] = bsel_q ? base_lvl  : other_lvl;
  assign line_lvl[0] = bsel_q ? other_lvl : base_lvl;

  for (genvar i = 0; i < N_LINES; i++) begin : g_pad
    lrc_line_pad u_pad (
      .mode (dir_q[2*i +: 2]),
      .lvl  (line_lvl[i]),
      .oe   (line_oe[i]),
      .dout (line_do[i])
    );
  end

  assign a_oe      = line_oe[1];
  assign a_do      = line_do[1];
  assign b_oe      = line_oe[0];
  assign b_do      = line_do[0];
  assign msb_first = ~order_q;
endmodule

// File: rtl/lrc_checker.sv
module lrc_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             base_tick,
  input logic             other_tick,
  input logic             base_lvl,
  input logic             other_lvl,
  input logic [DIV_W-1:0] div_q,
  input logic [3:0]       dir_q,
  input logic             a_oe,
  input logic             b_oe
);
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> run_en);                                              // R10
  AST_OTHER_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    other_tick |-> base_tick);                                          // R5
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (base_lvl && other_lvl));                               // R10
  AST_BASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> (base_lvl != $past(base_lvl)));                       // R6
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en)) |-> ($stable(div_q) && $stable(dir_q)));  // R9
  AST_INPUT_ONLY_A: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q[3] |-> !a_oe);                                                // R7
  AST_INPUT_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q[1] |-> !b_oe);                                                // R7
endmodule

bind dual_line_rate_ctrl lrc_checker #(.DIV_W(DIV_W)) u_lrc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .base_tick  (base_tick),
  .other_tick (other_tick),
  .base_lvl   (base_lvl),
  .other_lvl  (other_lvl),
  .div_q      (div_q),
  .dir_q      (dir_q),
  .a_oe       (a_oe),
  .b_oe       (b_oe)
);

// File: tb/test_dual_line_rate_ctrl.sv
module test_dual_line_rate_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [10:0] cfg_wdata = '0;
  logic a_oe, a_do, b_oe, b_do, base_tick, other_tick, msb_first;

  int vectors = 0, errors = 0;
  bit cmp_on = 0;
  string phase = "R1 reset";

  // behavioural model state
  int m_div, m_k, m_bt;
  bit m_slow, m_bsel, m_order, m_bl, m_ol;
  bit [3:0] m_dir;

  always #(CLK_P/2) clk = ~clk;

  dual_line_rate_ctrl i_dual_line_rate_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .a_oe(a_oe), .a_do(a_do), .b_oe(b_oe), .b_do(b_do),
    .base_tick(base_tick), .other_tick(other_tick), .msb_first(msb_first));

  function automatic int eff(int d); return (d < 2) ? 2 : d; endfunction
  function automatic bit exp_btick(); return run_en && ((m_k % eff(m_div)) == eff(m_div) - 1); endfunction
  function automatic bit exp_otick();
    if (!m_slow) return exp_btick();
    return exp_btick() && ((m_bt % 8) == 7);
  endfunction
  function automatic bit pad_oe_m(bit [1:0] md, bit l);
    if (md[1]) return 0;
    return md[0] ? 1'b1 : !l;
  endfunction
  function automatic bit pad_do_m(bit [1:0] md, bit l);
    return (md == 2'b01) ? l : 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_slow = 0; m_bsel = 0; m_order = 0; m_dir = 0;
      m_k = 0; m_bt = 0; m_bl = 1; m_ol = 1;
    end else begin
      bit bt, ot;
      bt = exp_btick(); ot = exp_otick();
      if (run_en) begin
        if (bt) begin m_bl = !m_bl; m_bt++; end
        if (ot) m_ol = !m_ol;
        m_k++;
      end else begin
        m_k = 0; m_bt = 0; m_bl = 1; m_ol = 1;
      end
      if (cfg_we && !run_en) begin
        if (cfg_sel) m_dir = cfg_wdata[3:0];
        else begin
          m_order = cfg_wdata[0]; m_bsel = cfg_wdata[1];
          m_slow = cfg_wdata[2]; m_div = int'(cfg_wdata[10:3]);
        end
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] got %0d expected %0d at %0t", tag, phase, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    bit la, lb;
    la = m_bsel ? m_bl : m_ol;
    lb = m_bsel ? m_ol : m_bl;
    chk("R2 base_tick", base_tick, exp_btick());
    chk("R5 other_tick", other_tick, exp_otick());
    chk("R4/R6/R7 a_oe", a_oe, pad_oe_m(m_dir[3:2], la));
    chk("R4/R6/R7 a_do", a_do, pad_do_m(m_dir[3:2], la));
    chk("R4/R6/R7 b_oe", b_oe, pad_oe_m(m_dir[1:0], lb));
    chk("R4/R6/R7 b_do", b_do, pad_do_m(m_dir[1:0], lb));
    chk("R8 msb_first", msb_first, !m_order);
  end

  task automatic wr(bit sel, logic [10:0] d);
    @(posedge clk); #1; cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
  endtask
  function automatic logic [10:0] ctl(int div, bit slow, bit bsel, bit order);
    return {8'(div), slow, bsel, order};
  endfunction
  task automatic run_for(int n);
    @(posedge clk); #1; run_en = 1;
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic stop();
    @(posedge clk); #1; run_en = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; cmp_on = 1;
    @(negedge clk);
    chk("R1 a_oe", a_oe, 0); chk("R1 b_oe", b_oe, 0);
    chk("R1 msb_first", msb_first, 1); chk("R1 base_tick", base_tick, 0);
    rst_n = 1;
    phase = "R1 idle"; repeat (5) @(posedge clk);
    phase = "R2 div4 A base";
    wr(0, ctl(4, 0, 1, 0)); wr(1, 4'b0100);
    run_for(100);
    phase = "R10 stop"; stop();
    @(negedge clk);
    chk("R10 a_do idle high", a_do, 1);
    chk("R10 a_oe driven", a_oe, 1);
    phase = "R3 div1 slow B base";
    wr(0, ctl(1, 1, 0, 1)); wr(1, 4'b0010);
    run_for(100);
    phase = "R9 writes during run";
    wr(0, ctl(9, 0, 1, 0)); wr(1, 4'b0101);
    repeat (60) @(posedge clk);
    phase = "R10 short drop"; stop();
    run_for(40);
    stop();
    phase = "R3 div0 push-pull";
    wr(0, ctl(0, 0, 0, 0)); wr(1, 4'b0101);
    run_for(50); stop();
    phase = "R2 div60 400k slow";
    wr(0, ctl(60, 1, 1, 0)); wr(1, 4'b0100);
    run_for(2000); stop();
    phase = "R5 div7 slow both od";
    wr(0, ctl(7, 1, 0, 1)); wr(1, 4'b0000);
    run_for(600); stop();
    phase = "R7 input only";
    wr(1, 4'b1111);
    run_for(50); stop();
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule